// File: doc/BRIEF.md
# Register-Mapped 64-Source Interrupt Request Aggregator

This block gathers 64 interrupt sources behind an APB register interface and reduces them to a single registered request line towards a processor. Each source is handled either as a level or as a pulse. The choice is fixed per source by a parameter mask. A pulse source latches its rising edge into a sticky flag that only a software write of 0 removes. A level source is used as it stands on its input.

Sixty-four routing channels each pick one physical source through a byte-wide select slot. A channel's pending bit is the state of its selected source gated by that channel's enable bit. Software reads the pending bits as two 32-bit words. The request output is the OR of all pending bits, gated by a global enable bit and registered once. The reset input is expected to be synchronized upstream.

Top module: `irq_hub_apb`

## Requirements
- R1: After reset the control bit, every enable bit, every flag and `irq_o` are 0, and select slot c holds c (identity routing, so the word at 0x40 reads 32'h00010203).
- R2: Offsets are: control 0x00, flag low 0x08, enable low 0x10, pending low 0x14, flag high 0x20, enable high 0x28, pending high 0x2C, select words 0x40 to 0x7C. Every other offset reads 0. `pready` is always 1 and `pslverr` is always 0.
- R3: Control bit 31 is the global enable and is the only control bit that reads back. While it is 0, `irq_o` is 0 in the following cycle, whatever is pending.
- R4: For a pulse-mode source (its bit in `PULSE_MASK` set), a 0-to-1 change of the input between two clock edges sets its flag bit. The flag bit stays set after the input returns to 0.
- R5: A write to a flag word clears each bit written 0 and leaves each bit written 1 unchanged. An edge arriving on the same clock edge as a clear leaves the bit set.
- R6: A level-mode source reads 0 in its flag bit, and its state is the live input value.
- R7: Select word 0x40+4k holds channels 4k..4k+3, with channel 4k+j in bits [8*(3-j)+5 : 8*(3-j)]. Bits 7:6 of each byte read 0.
- R8: Pending bit c (bit c of the low word for c<32, bit c-32 of the high word otherwise) equals the state of the source selected by slot c ANDed with enable bit c. Writes to the pending words have no effect.
- R9: `irq_o` is 1 exactly in the cycle after one in which the global enable is 1 and at least one pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| src_i | input | NUM_SRC | Interrupt source inputs |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a software clear of a flag that lands on the same clock edge as a fresh rising edge on that pulse source. Random stimulus almost never lines these up. The bench therefore has a write task that changes the source inputs in the access phase of the flag write, so that both reach the same edge. Re-routing a channel to a source that is not its own is also forced directly: a select slot is rewritten and a different source is then driven, and the stimulus reads back which pending bit responds.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [11:0] OFF_CTRL     = 12'h000;
  localparam logic [11:0] OFF_FLAG_LO  = 12'h008;
  localparam logic [11:0] OFF_EN_LO    = 12'h010;
  localparam logic [11:0] OFF_PEND_LO  = 12'h014;
  localparam logic [11:0] OFF_FLAG_HI  = 12'h020;
  localparam logic [11:0] OFF_EN_HI    = 12'h028;
  localparam logic [11:0] OFF_PEND_HI  = 12'h02C;
  localparam logic [11:0] OFF_SEL_BASE = 12'h040;
  localparam int          CTRL_EN_BIT  = 31;

  // bit position of a channel's slot inside its select word
  function automatic int slot_lsb(input int ch);
    return 8 * (3 - (ch % 4));
  endfunction
endpackage

// File: rtl/irq_hub_latch.sv
module irq_hub_latch #(
  parameter int                  NUM_SRC    = 64,
  parameter logic [NUM_SRC-1:0]  PULSE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] state_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (PULSE_MASK[s]) begin : g_pulse
      logic prev_q, flag_q, flag_d, rise;
      always_comb begin
        rise   = src_i[s] & ~prev_q;
        flag_d = (flag_q & ~clr_i[s]) | rise;   // set beats clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          prev_q <= src_i[s];
          flag_q <= flag_d;
        end
      end
      assign flag_o[s]  = flag_q;
      assign state_o[s] = flag_q;
    end else begin : g_level
      logic unused_clr;
      assign unused_clr = clr_i[s];
      assign flag_o[s]  = 1'b0;
      assign state_o[s] = src_i[s];
    end
  end
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs import irq_hub_pkg::*; #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic                       gen_en_o,
  output logic [NUM_SRC-1:0]         en_o,
  output logic [NUM_SRC*IDX_W-1:0]   sel_o
);
  localparam int SEL_WORDS = NUM_SRC / 4;

  logic                gen_en_q, gen_en_d;
  logic [NUM_SRC-1:0]  en_q, en_d;
  logic [IDX_W-1:0]    sel_q [NUM_SRC];
  logic [IDX_W-1:0]    sel_d [NUM_SRC];

  logic wr_ctrl, wr_en_lo, wr_en_hi;
  logic [SEL_WORDS-1:0] wr_sel;

  always_comb begin
    wr_ctrl  = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
    wr_en_lo = wr_i && (addr_i == ADDR_W'(OFF_EN_LO));
    wr_en_hi = wr_i && (addr_i == ADDR_W'(OFF_EN_HI));
    for (int k = 0; k < SEL_WORDS; k++)
      wr_sel[k] = wr_i && (addr_i == ADDR_W'(OFF_SEL_BASE) + ADDR_W'(4 * k));
  end

  // next-state
  always_comb begin
    gen_en_d = gen_en_q;
    en_d     = en_q;
    if (wr_ctrl)  gen_en_d     = wdata_i[CTRL_EN_BIT];
    if (wr_en_lo) en_d[31:0]   = wdata_i;
    if (wr_en_hi) en_d[63:32]  = wdata_i;
    for (int c = 0; c < NUM_SRC; c++) begin
      sel_d[c] = sel_q[c];
      if (wr_sel[c / 4]) sel_d[c] = wdata_i[slot_lsb(c) +: IDX_W];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_q <= 1'b0;
      en_q     <= '0;
      for (int c = 0; c < NUM_SRC; c++) sel_q[c] <= IDX_W'(c);
    end else begin
      gen_en_q <= gen_en_d;
      en_q     <= en_d;
      for (int c = 0; c < NUM_SRC; c++) sel_q[c] <= sel_d[c];
    end
  end

  assign gen_en_o = gen_en_q;
  assign en_o     = en_q;
  for (genvar c = 0; c < NUM_SRC; c++) begin : g_flat
    assign sel_o[c*IDX_W +: IDX_W] = sel_q[c];
  end
endmodule

// File: rtl/irq_hub_route.sv
module irq_hub_route #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       state_i,
  input  logic [NUM_SRC-1:0]       en_i,
  input  logic [NUM_SRC*IDX_W-1:0] sel_i,
  output logic [NUM_SRC-1:0]       pend_o
);
  for (genvar c = 0; c < NUM_SRC; c++) begin : g_chan
    logic [IDX_W-1:0] pick;
    assign pick      = sel_i[c*IDX_W +: IDX_W];
    assign pend_o[c] = state_i[pick] & en_i[c];
  end
endmodule

// File: rtl/irq_hub_apb.sv
module irq_hub_apb import irq_hub_pkg::*; #(
  parameter int                 NUM_SRC    = 64,
  parameter int                 ADDR_W     = 12,
  parameter logic [NUM_SRC-1:0] PULSE_MASK = 64'hFFFF_0000_FFFF_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int SEL_WORDS = NUM_SRC / 4;

  logic                      acc_wr;
  logic                      wr_flag_lo, wr_flag_hi, flag_wr_any;
  logic [NUM_SRC-1:0]        clr_mask;
  logic [NUM_SRC-1:0]        flag, state, en, pend;
  logic [NUM_SRC*IDX_W-1:0]  sel_flat;
  logic                      gen_en;
  logic                      irq_q, irq_d;

  always_comb begin
    acc_wr      = psel && penable && pwrite;
    wr_flag_lo  = acc_wr && (paddr == ADDR_W'(OFF_FLAG_LO));
    wr_flag_hi  = acc_wr && (paddr == ADDR_W'(OFF_FLAG_HI));
    flag_wr_any = wr_flag_lo || wr_flag_hi;
    clr_mask    = '0;
    if (wr_flag_lo) clr_mask[31:0]  = ~pwdata;
    if (wr_flag_hi) clr_mask[63:32] = ~pwdata;
  end

  irq_hub_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_i(acc_wr), .addr_i(paddr), .wdata_i(pwdata),
    .gen_en_o(gen_en), .en_o(en), .sel_o(sel_flat)
  );

  irq_hub_latch #(.NUM_SRC(NUM_SRC), .PULSE_MASK(PULSE_MASK)) latch_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr_mask),
    .flag_o(flag), .state_o(state)
  );

  irq_hub_route #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) route_i (
    .state_i(state), .en_i(en), .sel_i(sel_flat), .pend_o(pend)
  );

  // read mux, zero wait state
  always_comb begin
    prdata = '0;
    if (psel) begin
      if (paddr == ADDR_W'(OFF_CTRL))         prdata[CTRL_EN_BIT] = gen_en;
      else if (paddr == ADDR_W'(OFF_FLAG_LO)) prdata = flag[31:0];
      else if (paddr == ADDR_W'(OFF_FLAG_HI)) prdata = flag[63:32];
      else if (paddr == ADDR_W'(OFF_EN_LO))   prdata = en[31:0];
      else if (paddr == ADDR_W'(OFF_EN_HI))   prdata = en[63:32];
      else if (paddr == ADDR_W'(OFF_PEND_LO)) prdata = pend[31:0];
      else if (paddr == ADDR_W'(OFF_PEND_HI)) prdata = pend[63:32];
      else begin
        for (int k = 0; k < SEL_WORDS; k++) begin
          if (paddr == ADDR_W'(OFF_SEL_BASE) + ADDR_W'(4 * k)) begin
            for (int j = 0; j < 4; j++)
              prdata[slot_lsb(j) +: 8] = 8'(sel_flat[(4*k+j)*IDX_W +: IDX_W]);
          end
        end
      end
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_comb irq_d = gen_en && (|pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int                 NUM_SRC    = 64,
  parameter logic [NUM_SRC-1:0] PULSE_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pready,
  input logic               pslverr,
  input logic               irq_o,
  input logic               gen_en,
  input logic               flag_wr_any,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] flag,
  input logic [NUM_SRC-1:0] pend
);
  a_r2_apb_ok: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  a_r3_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !irq_o);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr_any |=> (($past(flag) & ~flag) == '0));

  a_r6_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag & ~PULSE_MASK) == '0);

  a_r8_pend_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en) == '0);

  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && (|pend)) |=> irq_o);

  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_en && (|pend)) |=> !irq_o);
endmodule

bind irq_hub_apb irq_hub_chk #(.NUM_SRC(NUM_SRC), .PULSE_MASK(PULSE_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .pready(pready), .pslverr(pslverr), .irq_o(irq_o),
  .gen_en(gen_en), .flag_wr_any(flag_wr_any), .en(en), .flag(flag), .pend(pend)
);

// File: tb/irq_hub_apb_tb.sv
module irq_hub_apb_tb_top;
  localparam logic [63:0] PULSE = 64'hFFFF_0000_FFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [63:0] src = '0;
  logic        irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, mon_on = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  irq_hub_apb #(.PULSE_MASK(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .src_i(src), .irq_o(irq_o)
  );

  // ---------------- reference model ----------------
  logic        m_ctrl;
  logic [63:0] m_en, m_flag, m_srcq;
  logic [5:0]  m_sel [64];
  logic        m_irq;

  function automatic logic [63:0] pend_model();
    logic [63:0] p;
    for (int c = 0; c < 64; c++) begin
      int s = int'(m_sel[c]);
      p[c] = (PULSE[s] ? m_flag[s] : src[s]) & m_en[c];
    end
    return p;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [63:0] p = pend_model();
    logic [31:0] r = '0;
    case (a)
      12'h000: r[31] = m_ctrl;
      12'h008: r = m_flag[31:0];
      12'h020: r = m_flag[63:32];
      12'h010: r = m_en[31:0];
      12'h028: r = m_en[63:32];
      12'h014: r = p[31:0];
      12'h02C: r = p[63:32];
      default:
        if (a >= 12'h040 && a < 12'h080 && a[1:0] == 2'b00) begin
          int k = int'((a - 12'h040) >> 2);
          for (int j = 0; j < 4; j++) r[8*(3-j) +: 8] = {2'b00, m_sel[4*k+j]};
        end
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 1'b0; m_en <= '0; m_flag <= '0; m_srcq <= '0; m_irq <= 1'b0;
      for (int c = 0; c < 64; c++) m_sel[c] <= 6'(c);
    end else begin : upd
      logic [63:0] rise_v, clr_v;
      rise_v = src & ~m_srcq;
      clr_v  = '0;
      if (psel && penable && pwrite) begin
        case (paddr)
          12'h000: m_ctrl <= pwdata[31];
          12'h008: clr_v[31:0]  = ~pwdata;
          12'h020: clr_v[63:32] = ~pwdata;
          12'h010: m_en[31:0]   <= pwdata;
          12'h028: m_en[63:32]  <= pwdata;
          default:
            if (paddr >= 12'h040 && paddr < 12'h080 && paddr[1:0] == 2'b00) begin
              int k = int'((paddr - 12'h040) >> 2);
              for (int j = 0; j < 4; j++) m_sel[4*k+j] <= pwdata[8*(3-j) +: 6];
            end
        endcase
      end
      m_flag <= ((m_flag & ~clr_v) | rise_v) & PULSE;
      m_srcq <= src;
      m_irq  <= m_ctrl && (pend_model() != 64'd0);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk("R9 irq_o", {31'b0, irq_o}, {31'b0, m_irq});
      chk("R2 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    end
  end

  // ---------------- APB tasks ----------------
  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d,
                        input bit chg = 0, input logic [63:0] ns = '0);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    if (chg) src = ns;    // edge reaches the same clock edge as the write
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    logic [31:0] d;
    apb_rd(a, d);
    chk(req, d, exp_read(a));
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    logic [11:0] alist [10];
    int seed_v;
    alist = '{12'h000, 12'h008, 12'h010, 12'h014, 12'h020,
              12'h028, 12'h02C, 12'h040, 12'h05C, 12'h07C};
    seed_v = $urandom(32'd20240611);

    repeat (4) @(negedge clk);
    rst_n = 1;
    mon_on = 1;

    // R1 reset state
    apb_rd(12'h000, d); chk("R1 ctrl", d, 32'h0);
    apb_rd(12'h010, d); chk("R1 enable low", d, 32'h0);
    apb_rd(12'h028, d); chk("R1 enable high", d, 32'h0);
    apb_rd(12'h008, d); chk("R1 flag low", d, 32'h0);
    apb_rd(12'h040, d); chk("R1 select word0", d, 32'h0001_0203);
    apb_rd(12'h07C, d); chk("R1 select word15", d, 32'h3C3D_3E3F);
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);

    // R2 unmapped offsets read 0
    apb_rd(12'h004, d); chk("R2 unmapped 0x04", d, 32'h0);
    apb_rd(12'h030, d); chk("R2 unmapped 0x30", d, 32'h0);
    apb_rd(12'h080, d); chk("R2 unmapped 0x80", d, 32'h0);
    apb_rd(12'h042, d); chk("R2 unaligned 0x42", d, 32'h0);

    // R3 only bit 31 of control reads back
    apb_wr(12'h000, 32'hFFFF_FFFF);
    apb_rd(12'h000, d); chk("R3 ctrl readback", d, 32'h8000_0000);
    apb_wr(12'h000, 32'h0);

    // R6 level source 3
    apb_wr(12'h010, 32'h0003_0008);
    set_src(64'h8);
    apb_rd(12'h014, d); chk("R6 level pend", d, 32'h0000_0008);
    apb_rd(12'h008, d); chk("R6 level flag zero", d, 32'h0);
    chk("R3 no irq while disabled", {31'b0, irq_o}, 32'h0);
    set_src(64'h0);
    apb_rd(12'h014, d); chk("R6 level follows input", d, 32'h0);

    // R4 pulse source 16 latches
    set_src(64'h1_0000);
    set_src(64'h0);
    apb_rd(12'h008, d); chk("R4 flag latched", d, 32'h0001_0000);
    apb_rd(12'h014, d); chk("R4 pend from flag", d, 32'h0001_0000);

    // R5 write 1 keeps, write 0 clears, set beats clear
    apb_wr(12'h008, 32'hFFFF_FFFF);
    apb_rd(12'h008, d); chk("R5 write one keeps", d, 32'h0001_0000);
    apb_wr(12'h008, 32'h0, 1, 64'h2_0000);
    apb_rd(12'h008, d); chk("R5 clear with new edge", d, 32'h0002_0000);
    set_src(64'h2_0000);
    set_src(64'h0);
    apb_wr(12'h008, 32'hFFFD_FFFF, 1, 64'h2_0000);
    apb_rd(12'h008, d); chk("R5 set beats same-edge clear", d, 32'h0002_0000);
    set_src(64'h0);
    apb_wr(12'h008, 32'h0);
    apb_rd(12'h008, d); chk("R5 clear", d, 32'h0);

    // R9 request
    apb_wr(12'h000, 32'h8000_0000);
    set_src(64'h8);
    chk("R9 irq with pend", {31'b0, irq_o}, 32'h1);
    set_src(64'h0);
    chk("R9 irq drops", {31'b0, irq_o}, 32'h0);

    // R7 re-route channel 0 to source 5
    apb_wr(12'h040, 32'hC500_0000);
    apb_rd(12'h040, d); chk("R7 slot layout", d, 32'h0500_0000);
    apb_wr(12'h010, 32'h0000_0001);
    set_src(64'h20);
    apb_rd(12'h014, d); chk("R7 routed pend", d, 32'h0000_0001);
    set_src(64'h0);
    apb_wr(12'h040, 32'h0001_0203);

    // R8 pending is read-only
    apb_wr(12'h010, 32'h0000_0008);
    set_src(64'h8);
    apb_wr(12'h014, 32'h0);
    apb_rd(12'h014, d); chk("R8 pend write ignored", d, 32'h0000_0008);
    apb_wr(12'h02C, 32'hFFFF_FFFF);
    apb_rd(12'h02C, d); chk("R8 high pend write ignored", d, 32'h0);

    // random mix, R4 R5 R6 R7 R8 R9 against the model
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 7));
      case (op)
        0: apb_wr(($urandom_range(0, 1) != 0) ? 12'h010 : 12'h028, $urandom());
        1: apb_wr(12'h040 + 12'(4 * $urandom_range(0, 15)), $urandom());
        2: set_src({$urandom(), $urandom()});
        3: apb_wr(($urandom_range(0, 1) != 0) ? 12'h008 : 12'h020, $urandom(),
                  1, {$urandom(), $urandom()});
        4: apb_wr(12'h000, $urandom());
        5: rd_chk("R8 random read", alist[$urandom_range(0, 9)]);
        6: rd_chk("R2 random offset", 12'(4 * $urandom_range(0, 63)));
        default: rd_chk("R4 random flag", ($urandom_range(0, 1) != 0) ? 12'h008 : 12'h020);
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule